// File: doc/BRIEF.md
# Single-Wire Bus Time-Slot Master

This block drives one shared open-drain wire that idles high through an external pull-up. The master never drives the wire high. It either pulls the wire low or lets it go. A host gives it one command at a time: a bus reset with a presence check, a single-bit write, or a single-bit read. The block turns each command into a time slot whose timing is set to the microsecond. The timing comes from a tick that is derived from the system clock through the parameter `CLKS_PER_US`. When the slot is over, the block raises `done` for one cycle and presents its result on `rsp_bit`. For a reset the result is the presence flag, for a read it is the bit that was sampled, and for a write it is the bit that was written.

The pad is modelled as an active-low enable `bus_oe_n`. While it is 0, the wire is pulled to 0. The level of the wire comes back on `bus_in`, which passes through a two-stage synchronizer before any sample is taken. Durations are counted in whole microseconds from the clock edge that accepts the command.

The controller has six states:
- `ST_IDLE` accepts a command.
- `ST_RST_LOW` holds the reset pulse.
- `ST_RST_LISTEN` releases the wire and takes the presence sample.
- `ST_SLOT_LOW` holds the low part of a bit slot.
- `ST_SLOT_REL` releases the wire for the rest of the slot and takes the read sample.
- `ST_RECOVER` is the released gap between slots.

Its transitions are:
- `ST_IDLE` to `ST_RST_LOW`, on an accepted reset.
- `ST_IDLE` to `ST_SLOT_LOW`, on an accepted write or read.
- `ST_RST_LOW` to `ST_RST_LISTEN`, at 480 µs.
- `ST_RST_LISTEN` to `ST_IDLE`, at 960 µs, with `done`.
- `ST_SLOT_LOW` to `ST_SLOT_REL`, at the end of a low time shorter than the slot.
- `ST_SLOT_LOW` to `ST_RECOVER`, when the low time fills the 60 µs slot (write-0).
- `ST_SLOT_REL` to `ST_RECOVER`, at 60 µs.
- `ST_RECOVER` to `ST_IDLE`, at 65 µs, with `done`.

Top module: `ow_master`

## Requirements
- R1: After reset, `bus_oe_n` is 1 (wire released), and `busy`, `done` and `rsp_bit` are 0.
- R2: A reset command pulls the wire low (`bus_oe_n`=0) for exactly 480 µs (480·CLKS_PER_US cycles). The pull starts in the cycle after acceptance, and the wire is then released.
- R3: `done` for a reset comes 960 µs after acceptance. The presence flag in `rsp_bit` is 1 when the synchronized wire reads low 550 µs after acceptance (70 µs after release), and 0 otherwise. Because of the synchronizer, the level that counts is the one on `bus_in` two cycles before that point.
- R4: A write with `cmd_bit`=1 pulls the wire low for 6 µs and then releases it. `done` follows 65 µs after acceptance (a 60 µs slot plus 5 µs of recovery), with `rsp_bit`=1.
- R5: A write with `cmd_bit`=0 pulls the wire low for 60 µs. `done` follows 65 µs after acceptance, with `rsp_bit`=0.
- R6: A read pulls the wire low for 6 µs and samples the synchronized wire 14 µs after acceptance. The bench relates this to `bus_in` two cycles before that point. `done` follows at 65 µs, and `rsp_bit` is the sampled level (low gives 0, high gives 1).
- R7: `cmd_op` encoding: 2'b01 is reset, 2'b10 is write of `cmd_bit`, 2'b11 is read, and 2'b00 is no operation. A no-operation request leaves `busy` at 0 and `bus_oe_n` at 1.
- R8: `busy` is 1 from the cycle after acceptance until the command completes. Any request made while `busy` is 1 is ignored, and the wire is never pulled low while `busy` is 0.
- R9: `done` is a single-cycle pulse in the first cycle after `busy` falls. `rsp_bit` changes only together with `done` and holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when `busy` is 0 |
| cmd_op | input | 2 | Command code (see R7) |
| cmd_bit | input | 1 | Value to write for a write command |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle completion strobe |
| rsp_bit | output | 1 | Presence flag, read bit, or echoed write bit |
| bus_oe_n | output | 1 | Active-low pull-down enable for the wire |
| bus_in | input | 1 | Raw level of the wire |

## Verification
Every duration counts from the accepting clock edge, so results fall at fixed offsets from it:
- the wire falls in the very next cycle;
- the wire rises after 480, 6 or 60 µs;
- `done` appears after 960 µs for a reset and after 65 µs for a bit slot.

Wire samples take the level of `bus_in` two cycles before the 550 µs or 14 µs mark, because of the synchronizer. The bench runs a behavioural model that keeps a cycle count from acceptance and derives the expected `bus_oe_n`, `busy`, `done` and `rsp_bit` from these offsets. It compares them with the design on the falling edge of every clock. The scripted slave in the bench pulls the wire around those sampling points so that every presence and read outcome is decided clearly.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } ow_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_LISTEN,
        ST_SLOT_LOW,
        ST_SLOT_REL,
        ST_RECOVER
    } ow_state_e;

endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
    parameter int CLKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = $clog2(CLKS_PER_US + 1);

    logic [CW-1:0] sub_q;

    assign tick = (sub_q == CW'(CLKS_PER_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (clear || tick) begin
            sub_q <= '0;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end
endmodule

// File: rtl/ow_us_counter.sv
module ow_us_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] us
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us <= '0;
        end else if (clear) begin
            us <= '0;
        end else if (tick) begin
            us <= us + 1'b1;
        end
    end
endmodule

// File: rtl/ow_input_sync.sv
module ow_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= 1'b1;
                end else if (i == 0) begin
                    stage_q[i] <= d;
                end else begin
                    stage_q[i] <= stage_q[(i > 0) ? i - 1 : 0];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int CLKS_PER_US    = 125,
    parameter int SYNC_STAGES    = 2,
    parameter int RST_LOW_US     = 480,
    parameter int RST_WAIT_US    = 480,
    parameter int PRES_SAMPLE_US = 70,
    parameter int SLOT_US        = 60,
    parameter int W1_LOW_US      = 6,
    parameter int W0_LOW_US      = 60,
    parameter int RD_LOW_US      = 6,
    parameter int RD_SAMPLE_US   = 14,
    parameter int RECOVERY_US    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bit,
    output logic       busy,
    output logic       done,
    output logic       rsp_bit,
    output logic       bus_oe_n,
    input  logic       bus_in
);
    localparam int RST_END_US  = RST_LOW_US + RST_WAIT_US;
    localparam int PRES_AT_US  = RST_LOW_US + PRES_SAMPLE_US;
    localparam int SLOT_END_US = SLOT_US + RECOVERY_US;
    localparam int UW          = $clog2(RST_END_US + SLOT_END_US + 1);

    ow_state_e     state_q, state_d;
    ow_op_e        op_q;
    logic          bit_q;
    logic [UW-1:0] low_len_q;
    logic          samp_q;
    logic          rsp_q;
    logic          done_q;

    logic          tick;
    logic [UW-1:0] us;
    logic          wire_s;
    logic          accept;
    logic          finish;

    assign accept = cmd_valid && (state_q == ST_IDLE) && (ow_op_e'(cmd_op) != OP_NONE);

    ow_us_tick #(.CLKS_PER_US(CLKS_PER_US)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (tick)
    );

    ow_us_counter #(.W(UW)) i_us (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (tick),
        .us    (us)
    );

    ow_input_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (wire_s)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (ow_op_e'(cmd_op) == OP_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
                end
            end
            ST_RST_LOW: begin
                if (tick && us == UW'(RST_LOW_US - 1)) state_d = ST_RST_LISTEN;
            end
            ST_RST_LISTEN: begin
                if (tick && us == UW'(RST_END_US - 1)) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_SLOT_LOW: begin
                if (tick && us == low_len_q - 1'b1) begin
                    state_d = (low_len_q >= UW'(SLOT_US)) ? ST_RECOVER : ST_SLOT_REL;
                end
            end
            ST_SLOT_REL: begin
                if (tick && us == UW'(SLOT_US - 1)) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (tick && us == UW'(SLOT_END_US - 1)) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Command capture, sampling and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_NONE;
            bit_q     <= 1'b0;
            low_len_q <= '0;
            samp_q    <= 1'b0;
            rsp_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                op_q  <= ow_op_e'(cmd_op);
                bit_q <= cmd_bit;
                if (ow_op_e'(cmd_op) == OP_READ) begin
                    low_len_q <= UW'(RD_LOW_US);
                end else if (cmd_bit) begin
                    low_len_q <= UW'(W1_LOW_US);
                end else begin
                    low_len_q <= UW'(W0_LOW_US);
                end
            end
            if (state_q == ST_RST_LISTEN && tick && us == UW'(PRES_AT_US - 1)) begin
                samp_q <= !wire_s;
            end
            if (state_q == ST_SLOT_REL && op_q == OP_READ && tick &&
                us == UW'(RD_SAMPLE_US - 1)) begin
                samp_q <= wire_s;
            end
            if (finish) begin
                rsp_q <= (op_q == OP_WRITE) ? bit_q : samp_q;
            end
        end
    end

    // Outputs
    always_comb begin
        bus_oe_n = !(state_q == ST_RST_LOW || state_q == ST_SLOT_LOW);
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        rsp_bit  = rsp_q;
    end
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       rsp_bit,
    input logic       bus_oe_n
);
    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> bus_oe_n);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    rsp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rsp_bit));

    // R2
    low_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe_n) |-> $rose(busy));

    // R7
    noop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == 2'b00) |=> !busy);
endmodule

bind ow_master ow_master_chk i_ow_master_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .rsp_bit   (rsp_bit),
    .bus_oe_n  (bus_oe_n)
);

// File: tb/test_ow_master.sv
module test_ow_master;
    localparam int C = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_bit = 1'b0;
    logic       busy, done, rsp_bit, bus_oe_n;
    logic       bus_in;
    logic       slave_pull;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural model state
    logic m_busy = 1'b0, m_done = 1'b0, m_rsp = 1'b0, m_val = 1'b1;
    int   m_cnt = 0, m_total = 0, m_low = 0, m_samp = -1;
    int   m_kind = 0; // 1 reset, 2 write, 3 read
    logic m_wbit = 1'b0;
    int   pull_from = 0, pull_to = 0;

    always #4 clk = ~clk;

    assign slave_pull = m_busy && (m_cnt >= pull_from) && (m_cnt < pull_to);
    assign bus_in = bus_oe_n & ~slave_pull;

    ow_master #(.CLKS_PER_US(C)) i_ow_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .busy(busy), .done(done), .rsp_bit(rsp_bit),
        .bus_oe_n(bus_oe_n), .bus_in(bus_in)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_rsp <= 1'b0; m_cnt <= 0;
        end else if (m_busy) begin
            if (m_cnt + 1 == m_samp) m_val <= bus_in;
            if (m_cnt + 1 == m_total) begin
                m_busy <= 1'b0;
                m_done <= 1'b1;
                if (m_kind == 1)      m_rsp <= ~m_val;
                else if (m_kind == 2) m_rsp <= m_wbit;
                else                  m_rsp <= m_val;
            end else begin
                m_done <= 1'b0;
            end
            m_cnt <= m_cnt + 1;
        end else begin
            m_done <= 1'b0;
            if (cmd_valid && cmd_op != 2'b00) begin
                m_busy <= 1'b1;
                m_cnt  <= 0;
                m_wbit <= cmd_bit;
                if (cmd_op == 2'b01) begin
                    m_kind <= 1; m_total <= 960 * C; m_low <= 480 * C; m_samp <= 550 * C - 2;
                end else if (cmd_op == 2'b10) begin
                    m_kind <= 2; m_total <= 65 * C; m_low <= (cmd_bit ? 6 : 60) * C; m_samp <= -1;
                end else begin
                    m_kind <= 3; m_total <= 65 * C; m_low <= 6 * C; m_samp <= 14 * C - 2;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s got %b expected %b at cycle %0d", req, what, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            check(tag, "bus_oe_n", bus_oe_n, !(m_busy && m_cnt < m_low));
            check("R8", "busy", busy, m_busy);
            check("R9", "done", done, m_done);
            check(tag, "rsp_bit", rsp_bit, m_rsp);
        end
    end

    task automatic issue(input logic [1:0] op, input logic b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic wait_done();
        while (!m_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        tag = "R1";
        check("R1", "idle bus_oe_n", bus_oe_n, 1'b1);
        check("R1", "idle busy", busy, 1'b0);
        check("R1", "idle done", done, 1'b0);
        check("R1", "idle rsp_bit", rsp_bit, 1'b0);

        // R7 no-operation is ignored
        tag = "R7";
        issue(2'b00, 1'b1);
        repeat (5) @(negedge clk);
        check("R7", "noop busy", busy, 1'b0);
        check("R7", "noop bus_oe_n", bus_oe_n, 1'b1);

        // R2 / R3 reset with no slave: presence 0
        tag = "R3"; pull_from = 0; pull_to = 0;
        issue(2'b01, 1'b0);
        wait_done();
        check("R3", "no presence", rsp_bit, 1'b0);

        // R2 / R3 reset with a slave answering 30..150 us after release
        tag = "R2"; pull_from = 510 * C; pull_to = 630 * C;
        issue(2'b01, 1'b0);
        wait_done();
        check("R3", "presence", rsp_bit, 1'b1);

        // R4 write 1, with an ignored read request while busy (R8)
        tag = "R4"; pull_from = 0; pull_to = 0;
        issue(2'b10, 1'b1);
        repeat (20) @(negedge clk);
        issue(2'b11, 1'b0);
        wait_done();
        check("R4", "write1 echo", rsp_bit, 1'b1);

        // R5 write 0
        tag = "R5";
        issue(2'b10, 1'b0);
        wait_done();
        check("R5", "write0 echo", rsp_bit, 1'b0);

        // R6 read with slave holding low to 30 us: reads 0
        tag = "R6"; pull_from = 2 * C; pull_to = 30 * C;
        issue(2'b11, 1'b0);
        wait_done();
        check("R6", "read low", rsp_bit, 1'b0);

        // R6 read with no slave: reads 1
        pull_from = 0; pull_to = 0;
        issue(2'b11, 1'b0);
        wait_done();
        check("R6", "read high", rsp_bit, 1'b1);

        // R6 read with slave releasing at 10 us: reads 1
        pull_from = 2 * C; pull_to = 10 * C;
        issue(2'b11, 1'b0);
        wait_done();
        check("R6", "read short pull", rsp_bit, 1'b1);

        // R9 back-to-back: new command in the done cycle
        tag = "R9"; pull_from = 2 * C; pull_to = 30 * C;
        issue(2'b11, 1'b0);
        while (!m_done) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_bit = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        check("R9", "read result held", rsp_bit, 1'b0);
        wait_done();
        check("R9", "back-to-back write", rsp_bit, 1'b0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule